// File: doc/BRIEF.md
# Virtual interrupt claim/complete controller

This block is a register unit that gives a guest the pending and claim/complete view of a platform interrupt controller. It tracks a pending bitmap and an active bitmap over a parameterised number of interrupt sources and drives one virtual external-interrupt line toward the guest hart. A hypervisor injects interrupts by writing the pending words. The guest takes the lowest-numbered pending source by reading its context's claim register, and retires a source by writing the source number back to that register.

All other accesses are relayed unchanged to a downstream host-controller port, and the host's read data is returned to the requester. These are accesses to source priorities, enables and per-context thresholds. A completion write is applied locally and also relayed. Priority arbitration, threshold masking and enable filtering are not applied here. Requests arrive on a 32-bit valid/ready bus, and each request produces exactly one response beat carrying data and an error flag.

A four-state machine sequences each request. IDLE accepts a request. It goes to RESP for errors and for the locally handled pending and claim-read accesses, and to FWD for relayed accesses and completion writes. FWD holds the host request until the host accepts it, then moves to WAIT. WAIT holds until the host returns a result, then moves to RESP. RESP drives the response for one cycle and returns to IDLE.

Top module: `vclaim_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `vext_irq` is 0 and every pending word reads as 0.
- R2: A request is answered with `rsp_err`=1 and `rsp_rdata`=0, and changes no state, in any of these cases: its size code is not 2 (`req_size`: 0 = byte, 1 = half, 2 = word), its address is not word aligned, or it names a pending word at or beyond NUM_SRC/32.
- R3: Pending words start at 0x1000. A read of the word at 0x1000+4k returns, in bit i, the pending state of source 32k+i.
- R4: A write to a pending word sets the pending bit of each source whose data bit is 1 and leaves every other pending bit unchanged. Source 0 is reserved and never becomes pending.
- R5: From the cycle after a pending-word write is accepted, `vext_irq` is 1 if any source is pending.
- R6: A read of a claim register returns the lowest-numbered pending source. It clears that source's pending bit and marks it active, all in the same access.
- R7: A claim read with nothing pending returns 0 and changes no state.
- R8: A write to a claim register clears the active mark of the source named by the write data. It is also relayed to the host port as a write with the same address and data.
- R9: On a claim-register write, `vext_irq` drops to 0 if no source is pending and otherwise stays as it was. A claim read does not change `vext_irq`.
- R10: Some accesses are relayed to the host port with unchanged direction, address and data: those below 0x1000 (priority), those from 0x2000 up to the context base 0x200000 (enable), and those at offset 0 of a context (threshold). A relayed read returns the host's read data.
- R11: Context c occupies 0x200000 + c*0x1000, with its threshold at offset 0 and its claim register at offset 4. An access to a context index at or above NUM_CTX, or to any other offset inside a context, gets an error response and no host access.
- R12: One request is handled at a time. `req_ready` is 0 from the cycle after an accept until the response. Each request yields exactly one single-cycle `rsp_valid` beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code, only 2 (32-bit) is legal |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat |
| rsp_err | output | 1 | Error flag of the response |
| rsp_rdata | output | 32 | Read data of the response |
| host_valid | output | 1 | Relayed request to the host controller |
| host_ready | input | 1 | Host accepts the relayed request |
| host_write | output | 1 | Direction of the relayed request |
| host_addr | output | ADDR_W | Address of the relayed request |
| host_wdata | output | 32 | Data of the relayed request |
| host_rvalid | input | 1 | Host completion beat |
| host_rdata | input | 32 | Host read data |
| vext_irq | output | 1 | Virtual external-interrupt line |

## Verification
Some properties are checked by the assertions on every cycle:
- an injection never clears a pending bit;
- source 0 never becomes pending;
- a successful claim moves its source from pending to active;
- `vext_irq` only rises while something is pending and only falls while nothing is;
- responses last one cycle, and `req_ready` drops after each accept.

Other behaviour can only be shown by the bench's scenarios:
- the ordering of claims across words;
- the OR-merge of repeated injections;
- the relay of each register class with its exact address and data;
- error decoding of bad sizes, misalignment, out-of-range words and contexts.

// File: rtl/vclaim_pkg.sv
package vclaim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } vc_state_e;

    typedef enum logic [1:0] {
        OP_BAD   = 2'd0,
        OP_PEND  = 2'd1,
        OP_RELAY = 2'd2,
        OP_CLAIM = 2'd3
    } vc_op_e;

    localparam logic [1:0] SIZE_WORD = 2'd2;

endpackage

// File: rtl/vclaim_decode.sv
module vclaim_decode
    import vclaim_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int NUM_WORDS  = 2,
    parameter int NUM_CTX    = 2,
    parameter int PEND_BASE  = 32'h1000,
    parameter int ENA_BASE   = 32'h2000,
    parameter int CTX_BASE   = 32'h20_0000,
    parameter int CTX_STRIDE = 32'h1000,
    parameter int CLAIM_OFS  = 4,
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output vc_op_e            op,
    output logic [WIDX_W-1:0] word_idx
);
    logic [ADDR_W-1:0] pend_off;
    logic [ADDR_W-1:0] word_full;
    logic [ADDR_W-1:0] ctx_off;
    logic [ADDR_W-1:0] ctx_idx;
    logic [ADDR_W-1:0] ctx_in;

    always_comb begin
        pend_off  = addr - ADDR_W'(PEND_BASE);
        word_full = pend_off >> 2;
        ctx_off   = addr - ADDR_W'(CTX_BASE);
        ctx_idx   = ctx_off / ADDR_W'(CTX_STRIDE);
        ctx_in    = ctx_off % ADDR_W'(CTX_STRIDE);
        word_idx  = word_full[WIDX_W-1:0];

        if (size != SIZE_WORD || addr[1:0] != 2'b00) begin
            op = OP_BAD;
        end else if (addr < ADDR_W'(PEND_BASE)) begin
            op = OP_RELAY;
        end else if (addr < ADDR_W'(ENA_BASE)) begin
            op = (word_full < ADDR_W'(NUM_WORDS)) ? OP_PEND : OP_BAD;
        end else if (addr < ADDR_W'(CTX_BASE)) begin
            op = OP_RELAY;
        end else if (ctx_idx >= ADDR_W'(NUM_CTX)) begin
            op = OP_BAD;
        end else if (ctx_in == '0) begin
            op = OP_RELAY;
        end else if (ctx_in == ADDR_W'(CLAIM_OFS)) begin
            op = OP_CLAIM;
        end else begin
            op = OP_BAD;
        end
    end

endmodule

// File: rtl/vclaim_srcbank.sv
module vclaim_srcbank #(
    parameter int NUM_SRC   = 64,
    localparam int NUM_WORDS = NUM_SRC / 32,
    localparam int ID_W      = $clog2(NUM_SRC),
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inj_en,
    input  logic [WIDX_W-1:0] inj_idx,
    input  logic [31:0]       inj_data,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [31:0]       rd_word,
    input  logic              claim_en,
    output logic [ID_W-1:0]   claim_id,
    input  logic              cmpl_en,
    input  logic [31:0]       cmpl_id,
    output logic              any_pend,
    output logic              any_after_inj
);
    logic [NUM_SRC-1:0] pend_q, pend_d;
    logic [NUM_SRC-1:0] act_q, act_d;
    logic [NUM_SRC-1:0] inj_mask;
    logic [31:0]        words [NUM_WORDS];

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            assign words[w] = pend_q[w*32 +: 32];
        end
    endgenerate

    assign rd_word = words[rd_idx];

    // lowest pending source above the reserved 0
    always_comb begin
        claim_id = '0;
        for (int i = NUM_SRC - 1; i >= 1; i--) begin
            if (pend_q[i]) claim_id = ID_W'(i);
        end
    end

    always_comb begin
        inj_mask = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (inj_idx == WIDX_W'(w)) inj_mask[w*32 +: 32] = inj_data;
        end
        inj_mask[0] = 1'b0;
    end

    assign any_pend      = |pend_q;
    assign any_after_inj = |(pend_q | inj_mask);

    always_comb begin
        pend_d = pend_q;
        act_d  = act_q;
        if (inj_en) pend_d = pend_q | inj_mask;
        if (claim_en && claim_id != '0) begin
            pend_d[claim_id] = 1'b0;
            act_d[claim_id]  = 1'b1;
        end
        if (cmpl_en && cmpl_id < 32'(NUM_SRC)) act_d[cmpl_id[ID_W-1:0]] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= pend_d;
            act_q  <= act_d;
        end
    end

    // R4
    inject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R4
    src0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);

    // R6
    claim_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_en && claim_id != '0) |=>
            (act_q[$past(claim_id)] && !pend_q[$past(claim_id)]));

endmodule

// File: rtl/vclaim_ctrl.sv
module vclaim_ctrl
    import vclaim_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int NUM_SRC    = 64,
    parameter int NUM_CTX    = 2,
    parameter int PEND_BASE  = 32'h1000,
    parameter int ENA_BASE   = 32'h2000,
    parameter int CTX_BASE   = 32'h20_0000,
    parameter int CTX_STRIDE = 32'h1000,
    parameter int CLAIM_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              host_valid,
    input  logic              host_ready,
    output logic              host_write,
    output logic [ADDR_W-1:0] host_addr,
    output logic [31:0]       host_wdata,
    input  logic              host_rvalid,
    input  logic [31:0]       host_rdata,
    output logic              vext_irq
);
    localparam int NUM_WORDS = NUM_SRC / 32;
    localparam int ID_W      = $clog2(NUM_SRC);
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    vc_state_e         state_q, state_d;
    vc_op_e            op;
    logic [WIDX_W-1:0] word_idx;
    logic              accept;
    logic              inj_en, claim_en, cmpl_en;
    logic [31:0]       rd_word;
    logic [ID_W-1:0]   claim_id;
    logic              any_pend, any_after_inj;
    logic              err_q;
    logic [31:0]       rdata_q;
    logic              hwr_q;
    logic [ADDR_W-1:0] haddr_q;
    logic [31:0]       hdata_q;
    logic              vext_q;

    vclaim_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .NUM_CTX(NUM_CTX),
        .PEND_BASE(PEND_BASE), .ENA_BASE(ENA_BASE), .CTX_BASE(CTX_BASE),
        .CTX_STRIDE(CTX_STRIDE), .CLAIM_OFS(CLAIM_OFS)
    ) u_dec (
        .size(req_size), .addr(req_addr), .op(op), .word_idx(word_idx)
    );

    vclaim_srcbank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .inj_en(inj_en), .inj_idx(word_idx), .inj_data(req_wdata),
        .rd_idx(word_idx), .rd_word(rd_word),
        .claim_en(claim_en), .claim_id(claim_id),
        .cmpl_en(cmpl_en), .cmpl_id(req_wdata),
        .any_pend(any_pend), .any_after_inj(any_after_inj)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign inj_en   = accept && (op == OP_PEND) && req_write;
    assign claim_en = accept && (op == OP_CLAIM) && !req_write;
    assign cmpl_en  = accept && (op == OP_CLAIM) && req_write;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                if (op == OP_RELAY || (op == OP_CLAIM && req_write)) state_d = ST_FWD;
                else                                                 state_d = ST_RESP;
            end
            ST_FWD:  if (host_ready)  state_d = ST_WAIT;
            ST_WAIT: if (host_rvalid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        rsp_err    = rsp_valid && err_q;
        rsp_rdata  = rsp_valid ? rdata_q : 32'h0;
        host_valid = (state_q == ST_FWD);
        host_write = hwr_q;
        host_addr  = haddr_q;
        host_wdata = hdata_q;
        vext_irq   = vext_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
            hwr_q   <= 1'b0;
            haddr_q <= '0;
            hdata_q <= '0;
            vext_q  <= 1'b0;
        end else begin
            if (accept) begin
                err_q   <= (op == OP_BAD);
                rdata_q <= '0;
                hwr_q   <= req_write;
                haddr_q <= req_addr;
                hdata_q <= req_wdata;
                if (op == OP_PEND && !req_write)  rdata_q <= rd_word;
                if (claim_en)                     rdata_q <= 32'(claim_id);
            end
            if (state_q == ST_WAIT && host_rvalid && !hwr_q) rdata_q <= host_rdata;
            if (inj_en && any_after_inj)   vext_q <= 1'b1;
            if (cmpl_en && !any_pend)      vext_q <= 1'b0;
        end
    end

    // R12
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vext_irq) |-> any_pend);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vext_irq) |-> !any_pend);

endmodule

// File: tb/sim_vclaim_ctrl.sv
module sim_vclaim_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        host_valid;
    logic        host_ready = 1'b1;
    logic        host_write;
    logic [23:0] host_addr;
    logic [31:0] host_wdata;
    logic        host_rvalid = 1'b0;
    logic [31:0] host_rdata = '0;
    logic        vext_irq;

    always #10 clk = ~clk;

    vclaim_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .vext_irq(vext_irq)
    );

    typedef struct {
        logic        err;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int          host_cnt = 0;
    logic        last_hw;
    logic [23:0] last_ha;
    logic [31:0] last_hd;
    bit          host_pend = 0;
    logic [23:0] pend_ha;

    function automatic logic [31:0] host_val(input logic [23:0] a);
        return {8'h00, a} ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // host model: ready always high, result one cycle after the request
    always @(negedge clk) begin
        host_rvalid = 1'b0;
        if (host_pend) begin
            host_rvalid = 1'b1;
            host_rdata  = host_val(pend_ha);
            host_pend   = 0;
        end
        if (host_valid) begin
            host_cnt++;
            last_hw   = host_write;
            last_ha   = host_addr;
            last_hd   = host_wdata;
            pend_ha   = host_addr;
            host_pend = 1;
        end
    end

    // monitor: pops expected responses
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " err"},  {31'd0, rsp_err}, {31'd0, e.err});
                chk({e.tag, " data"}, rsp_rdata, e.data);
            end
        end
    end

    task automatic access(input logic wr, input logic [1:0] sz, input logic [23:0] a,
                          input logic [31:0] d, input logic e_err, input logic [31:0] e_data,
                          input string tag);
        exp_t e;
        e.err = e_err; e.data = e_data; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 vext_irq",  {31'd0, vext_irq},  32'd0);
        access(0, 2, 24'h1000, 0, 0, 32'h0, "R1 pending word0");
        access(0, 2, 24'h1004, 0, 0, 32'h0, "R1 pending word1");

        // R2 malformed requests
        access(1, 1, 24'h1000, 32'hF0, 1, 32'h0, "R2 half size write");
        access(0, 2, 24'h1002, 0, 1, 32'h0, "R2 misaligned read");
        access(1, 2, 24'h1008, 32'h1, 1, 32'h0, "R2 word beyond sources");
        access(0, 2, 24'h1000, 0, 0, 32'h0, "R2 no state change");
        chk("R2 vext unchanged", {31'd0, vext_irq}, 32'd0);

        // R4 / R5 injection
        access(1, 2, 24'h1000, 32'h11, 0, 32'h0, "R4 inject word0");
        chk("R5 vext after inject", {31'd0, vext_irq}, 32'd1);
        access(0, 2, 24'h1000, 0, 0, 32'h10, "R4 source0 ignored");
        access(1, 2, 24'h1004, 32'h8000_0001, 0, 32'h0, "R4 inject word1");
        access(0, 2, 24'h1004, 0, 0, 32'h8000_0001, "R3 word1 bits 32 and 63");
        access(1, 2, 24'h1000, 32'h4, 0, 32'h0, "R4 inject or");
        access(0, 2, 24'h1000, 0, 0, 32'h14, "R4 or merge keeps old bits");

        // R6 / R7 claims in source order, across contexts and words
        access(0, 2, 24'h200004, 0, 0, 32'd2, "R6 claim lowest");
        access(0, 2, 24'h1000, 0, 0, 32'h10, "R6 pending cleared");
        access(0, 2, 24'h201004, 0, 0, 32'd4, "R6 claim ctx1");
        access(0, 2, 24'h200004, 0, 0, 32'd32, "R6 claim word1 low");
        access(0, 2, 24'h200004, 0, 0, 32'd63, "R6 claim top source");
        access(0, 2, 24'h1004, 0, 0, 32'h0, "R6 word1 drained");
        access(0, 2, 24'h200004, 0, 0, 32'd0, "R7 claim none");
        access(0, 2, 24'h1000, 0, 0, 32'h0, "R7 state unchanged");
        chk("R9 claim keeps vext", {31'd0, vext_irq}, 32'd1);

        // R8 / R9 completion
        hc = host_cnt;
        access(1, 2, 24'h200004, 32'd2, 0, 32'h0, "R8 complete");
        chk("R8 host count", host_cnt, hc + 1);
        chk("R8 host write", {31'd0, last_hw}, 32'd1);
        chk("R8 host addr",  {8'd0, last_ha}, 32'h200004);
        chk("R8 host data",  last_hd, 32'd2);
        chk("R9 vext dropped", {31'd0, vext_irq}, 32'd0);
        access(1, 2, 24'h1000, 32'h100, 0, 32'h0, "R5 inject source8");
        chk("R5 vext set again", {31'd0, vext_irq}, 32'd1);
        access(1, 2, 24'h201004, 32'd4, 0, 32'h0, "R9 complete with pending");
        chk("R9 vext held", {31'd0, vext_irq}, 32'd1);

        // R10 relayed classes
        access(0, 2, 24'h000010, 0, 0, host_val(24'h10), "R10 priority read");
        chk("R10 priority dir",  {31'd0, last_hw}, 32'd0);
        chk("R10 priority addr", {8'd0, last_ha}, 32'h10);
        access(1, 2, 24'h002000, 32'h55, 0, 32'h0, "R10 enable write");
        chk("R10 enable addr", {8'd0, last_ha}, 32'h2000);
        chk("R10 enable data", last_hd, 32'h55);
        access(0, 2, 24'h201000, 0, 0, host_val(24'h201000), "R10 threshold read");
        chk("R10 threshold addr", {8'd0, last_ha}, 32'h201000);

        // R11 context decode errors
        hc = host_cnt;
        access(0, 2, 24'h202004, 0, 1, 32'h0, "R11 context out of range");
        access(1, 2, 24'h202000, 32'h7, 1, 32'h0, "R11 threshold out of range");
        access(0, 2, 24'h200008, 0, 1, 32'h0, "R11 bad offset");
        chk("R11 no host access", host_cnt, hc);
        access(0, 2, 24'h1000, 0, 0, 32'h100, "R11 pending untouched");

        // R12 busy while relayed access outstanding
        begin
            exp_t e;
            e.err = 0; e.data = host_val(24'h20); e.tag = "R12 relay response";
            exp_q.push_back(e);
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 24'h20;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R12 ready low while busy", {31'd0, req_ready}, 32'd0);
            chk("R12 no early response", {31'd0, rsp_valid}, 32'd0);
            while (exp_q.size() != 0) @(negedge clk);
            @(negedge clk);
            chk("R12 ready back", {31'd0, req_ready}, 32'd1);
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule